// File: doc/BRIEF.md
# Common-Start Hit Packet Builder

This block groups stop hits from four channels around a shared start event and turns each group into one variable-length packet. A start strobe opens a measurement window. Every accepted edge on a stop channel during that window is stamped with the number of clock cycles since the start. The stamp is stored with the channel number and flag bits as a 32-bit hit word. The window closes when the configured range runs out or when the next start arrives. The closed group is then sent on a 64-bit valid/ready stream. The stream carries a header word first, then the hit words packed two per data word.

Collection and emission use two separate storage banks. The next group can therefore be gathered while the previous one is still draining. A group that closes while the emitter is still busy cannot be handed over. That group is discarded and counted as missing. Start strobes that come too soon after the previous accepted start are ignored, so an open packet is never split by a start that is too close.

Top module: `common_start_packer`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid_o` is 0 and `missed_o` is 0 until the first packet is ready.
- R2: Each accepted start produces exactly one packet, and its header is the first word. Header bits [63:32] hold `coarse_time_i` as sampled in the start cycle. Bits [31:16] hold the number of data words, which is the hit count divided by two and rounded up. Bit 0 is the odd-count flag and bits [15:1] are 0. `out_last_o` marks the final word of the packet, and marks the header itself when the packet holds no hits.
- R3: Each hit word holds the channel number in bits [3:0] and the trailing-edge flag (1 = trailing) in bit 4. Bit 6 is the coarse-only flag, copied from `hit_coarse_i`. Bits 5 and 7 are 0. Bits [31:8] hold the offset, which is the number of cycles between the start cycle and the hit cycle.
- R4: Hit 2k goes in bits [31:0] of data word k and hit 2k+1 goes in bits [63:32]. When the hit count is odd, header bit 0 is 1 and the upper half of the last data word is 0. When the count is even, header bit 0 is 0.
- R5: Hits are emitted in order of their cycle. Hits from the same cycle are emitted in ascending channel order.
- R6: A hit is kept only if its offset is at most `cfg_range_i`. When the offset count passes the range, the packet closes without waiting for another start.
- R7: `cfg_edge_mode_i` bit 2c enables leading edges on channel c, and bit 2c+1 enables trailing edges on channel c. A hit whose edge is not enabled is dropped.
- R8: An accepted start closes the open packet. Hits in the same cycle as that start belong to the new packet, with offset 0.
- R9: A start that comes fewer than MIN_GAP cycles (default 2) after the previous accepted start is ignored. It neither closes nor restarts the open packet.
- R10: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o`, `out_data_o` and `out_last_o` hold their values.
- R11: A packet that closes while the previous packet is still being emitted is discarded, and `missed_o` increments by one (saturating).
- R12: A packet stores at most DEPTH hits (default 16). Later hits are dropped, and the header count never exceeds DEPTH/2 words.
- R13: Hits that arrive while no packet is open are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coarse_time_i | input | 32 | Absolute coarse time, copied into the header |
| start_i | input | 1 | Start strobe |
| hit_valid_i | input | NCH | Per-channel edge event |
| hit_trail_i | input | NCH | Per-channel edge type, 1 = trailing |
| hit_coarse_i | input | NCH | Per-channel coarse-only flag |
| cfg_edge_mode_i | input | 2*NCH | Per-channel leading/trailing enables |
| cfg_range_i | input | OFS_W | Largest offset that is kept |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Output word accepted |
| out_data_o | output | 64 | Header or packed hit pair |
| out_last_o | output | 1 | Final word of packet |
| missed_o | output | MISS_W | Count of discarded packets |

## Verification
Several hit patterns are driven against the packet builder:
- Same-cycle hits on several channels separate channel ordering from cycle ordering.
- Mixed edge types with partial enables separate the edge filter from the window cut.
- A hit placed exactly at the range limit, and another one cycle past it, pin down the inclusive boundary and the automatic close.
- Odd and even hit counts show the packing and the flag.
- A start close behind another start checks that too-close starts are ignored.
- A stalled consumer tells a held word apart from a dropped packet.
- A burst of more hits than the bank holds checks the capacity limit.

// File: rtl/csp_pkg.sv
package csp_pkg;
    localparam int TIME_W  = 32;
    localparam int HIT_W   = 32;
    localparam int WORD_W  = 64;
    localparam int NWORD_W = 16;

    typedef enum logic [1:0] {EM_IDLE, EM_HDR, EM_DATA} em_state_e;

    // low byte of a hit word: flag nibble over channel nibble
    function automatic logic [7:0] hit_tag(logic [3:0] ch, logic trail, logic coarse);
        return {1'b0, coarse, 1'b0, trail, ch};
    endfunction
endpackage

// File: rtl/csp_edge_filter.sv
module csp_edge_filter #(
    parameter int CH = 0
) (
    input  logic       valid_i,
    input  logic       trail_i,
    input  logic       coarse_i,
    input  logic [1:0] mode_i,
    output logic       keep_o,
    output logic [7:0] tag_o
);
    import csp_pkg::*;

    always_comb begin
        keep_o = valid_i && (trail_i ? mode_i[1] : mode_i[0]);
        tag_o  = hit_tag(4'(CH), trail_i, coarse_i);
    end
endmodule

// File: rtl/csp_emitter.sv
module csp_emitter #(
    parameter int DEPTH = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                load_i,
    input  logic                                load_bank_i,
    input  logic [$clog2(DEPTH+1)-1:0]          load_count_i,
    input  logic [csp_pkg::TIME_W-1:0]          load_time_i,
    input  logic [DEPTH*csp_pkg::HIT_W-1:0]     rd_words_i,
    output logic                                rd_bank_o,
    output logic                                busy_o,
    output logic                                out_valid_o,
    input  logic                                out_ready_i,
    output logic [csp_pkg::WORD_W-1:0]          out_data_o,
    output logic                                out_last_o
);
    import csp_pkg::*;

    localparam int CW    = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        em_state_e         state;
        logic              bank;
        logic [CW-1:0]     count;
        logic [TIME_W-1:0] stamp;
        logic [IDX_W-1:0]  widx;
    } em_t;

    em_t         em_d, em_q;
    logic [CW:0] nwords;
    int          lo_i;
    int          hi_i;

    always_comb begin
        em_d   = em_q;
        nwords = ({1'b0, em_q.count} + (CW+1)'(1)) >> 1;
        lo_i   = 2 * int'(em_q.widx);
        hi_i   = lo_i + 1;

        out_valid_o = (em_q.state != EM_IDLE);
        out_data_o  = '0;
        out_last_o  = 1'b0;

        if (em_q.state == EM_HDR) begin
            out_data_o = {em_q.stamp, NWORD_W'(nwords), 15'd0, em_q.count[0]};
            out_last_o = (nwords == '0);
        end else if (em_q.state == EM_DATA) begin
            out_data_o[HIT_W-1:0] = rd_words_i[lo_i*HIT_W +: HIT_W];
            if (hi_i < int'(em_q.count) && hi_i < DEPTH) begin
                out_data_o[WORD_W-1:HIT_W] = rd_words_i[hi_i*HIT_W +: HIT_W];
            end
            out_last_o = ((CW+1)'(em_q.widx) + (CW+1)'(1) == nwords);
        end

        case (em_q.state)
            EM_IDLE: if (load_i) begin
                em_d.state = EM_HDR;
                em_d.bank  = load_bank_i;
                em_d.count = load_count_i;
                em_d.stamp = load_time_i;
                em_d.widx  = '0;
            end
            EM_HDR: if (out_ready_i) begin
                em_d.state = (nwords == '0) ? EM_IDLE : EM_DATA;
                em_d.widx  = '0;
            end
            EM_DATA: if (out_ready_i) begin
                if (out_last_o) em_d.state = EM_IDLE;
                else            em_d.widx  = em_q.widx + IDX_W'(1);
            end
            default: em_d.state = EM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            em_q <= '{state: EM_IDLE, bank: 1'b0, count: '0, stamp: '0, widx: '0};
        end else begin
            em_q <= em_d;
        end
    end

    assign rd_bank_o = em_q.bank;
    assign busy_o    = (em_q.state != EM_IDLE);
endmodule

// File: rtl/common_start_packer.sv
module common_start_packer #(
    parameter int NCH     = 4,
    parameter int DEPTH   = 16,
    parameter int OFS_W   = 24,
    parameter int MIN_GAP = 2,
    parameter int MISS_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [31:0]                coarse_time_i,
    input  logic                       start_i,
    input  logic [NCH-1:0]             hit_valid_i,
    input  logic [NCH-1:0]             hit_trail_i,
    input  logic [NCH-1:0]             hit_coarse_i,
    input  logic [2*NCH-1:0]           cfg_edge_mode_i,
    input  logic [OFS_W-1:0]           cfg_range_i,
    output logic                       out_valid_o,
    input  logic                       out_ready_i,
    output logic [63:0]                out_data_o,
    output logic                       out_last_o,
    output logic [MISS_W-1:0]          missed_o
);
    import csp_pkg::*;

    localparam int CW    = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int GAP_W = $clog2(MIN_GAP + 1);

    typedef struct packed {
        logic                                open;
        logic [OFS_W:0]                      cnt;
        logic                                wbank;
        logic [CW-1:0]                       nhit;
        logic [TIME_W-1:0]                   stamp;
        logic [GAP_W-1:0]                    gap;
        logic [MISS_W-1:0]                   missed;
        logic [1:0][DEPTH-1:0][HIT_W-1:0]    banks;
    } col_t;

    col_t            col_d, col_q;
    logic [NCH-1:0]  keep;
    logic [7:0]      tag [NCH];
    logic            em_busy;
    logic            rd_bank;
    logic            start_ok, win_over, close_pkt, load, take;
    logic [CW-1:0]   pos;
    logic [OFS_W-1:0] ofs;

    for (genvar c = 0; c < NCH; c++) begin : g_filt
        csp_edge_filter #(.CH(c)) u_filt (
            .valid_i (hit_valid_i[c]),
            .trail_i (hit_trail_i[c]),
            .coarse_i(hit_coarse_i[c]),
            .mode_i  (cfg_edge_mode_i[2*c +: 2]),
            .keep_o  (keep[c]),
            .tag_o   (tag[c])
        );
    end

    always_comb begin
        col_d     = col_q;
        start_ok  = start_i && (col_q.gap >= GAP_W'(MIN_GAP));
        win_over  = col_q.cnt > {1'b0, cfg_range_i};
        close_pkt = col_q.open && (start_ok || win_over);
        load      = close_pkt && !em_busy;

        if (start_ok)             col_d.gap = GAP_W'(1);
        else if (col_q.gap != '1) col_d.gap = col_q.gap + GAP_W'(1);

        if (close_pkt) begin
            col_d.open = 1'b0;
            if (load)                    col_d.wbank  = ~col_q.wbank;
            else if (col_q.missed != '1) col_d.missed = col_q.missed + MISS_W'(1);
        end

        take = start_ok || (col_q.open && !win_over);
        if (start_ok) begin
            col_d.open  = 1'b1;
            col_d.cnt   = (OFS_W+1)'(1);
            col_d.stamp = coarse_time_i;
        end else if (take) begin
            col_d.cnt = col_q.cnt + (OFS_W+1)'(1);
        end

        pos = start_ok ? '0 : col_q.nhit;
        ofs = start_ok ? '0 : col_q.cnt[OFS_W-1:0];
        for (int c = 0; c < NCH; c++) begin
            if (take && keep[c] && pos < CW'(DEPTH)) begin
                col_d.banks[col_d.wbank][pos[IDX_W-1:0]] = {ofs, tag[c]};
                pos = pos + CW'(1);
            end
        end
        if (take) col_d.nhit = pos;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '{open: 1'b0, cnt: '0, wbank: 1'b0, nhit: '0, stamp: '0,
                       gap: '1, missed: '0, banks: '0};
        end else begin
            col_q <= col_d;
        end
    end

    csp_emitter #(.DEPTH(DEPTH)) u_emit (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .load_bank_i (col_q.wbank),
        .load_count_i(col_q.nhit),
        .load_time_i (col_q.stamp),
        .rd_words_i  (col_q.banks[rd_bank]),
        .rd_bank_o   (rd_bank),
        .busy_o      (em_busy),
        .out_valid_o (out_valid_o),
        .out_ready_i (out_ready_i),
        .out_data_o  (out_data_o),
        .out_last_o  (out_last_o)
    );

    assign missed_o = col_q.missed;
endmodule

// File: rtl/csp_checker.sv
module csp_checker #(
    parameter int DEPTH  = 16,
    parameter int MISS_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid_o,
    input logic              out_ready_i,
    input logic [63:0]       out_data_o,
    input logic              out_last_o,
    input logic [MISS_W-1:0] missed_o
);
    logic first_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          first_q <= 1'b1;
        else if (out_valid_o && out_ready_i) first_q <= out_last_o;
    end

    // R1
    p_quiet_in_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid_o && missed_o == '0));

    // R10
    p_hold_under_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=>
        (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

    // R2
    p_header_zero_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && first_q) |-> (out_data_o[15:1] == '0));

    // R12
    p_word_count_cap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && first_q) |-> (int'(out_data_o[31:16]) <= (DEPTH + 1) / 2));

    // R3
    p_hit_reserved_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !first_q) |->
        (!out_data_o[7] && !out_data_o[5] && !out_data_o[39] && !out_data_o[37]));

    // R11
    p_missed_steps_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (missed_o != '1) |=>
        (missed_o == $past(missed_o) || missed_o == $past(missed_o) + MISS_W'(1)));
endmodule

bind common_start_packer csp_checker #(.DEPTH(DEPTH), .MISS_W(MISS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_data_o (out_data_o),
    .out_last_o (out_last_o),
    .missed_o   (missed_o)
);

// File: tb/common_start_packer_tb_top.sv
module common_start_packer_tb_top;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] coarse_time_i;
    logic        start_i = 1'b0;
    logic [3:0]  hit_valid_i = '0, hit_trail_i = '0, hit_coarse_i = '0;
    logic [7:0]  cfg_edge_mode_i = 8'hFF;
    logic [23:0] cfg_range_i = 24'd100;
    logic        out_valid_o, out_ready_i = 1'b1, out_last_o;
    logic [63:0] out_data_o;
    logic [15:0] missed_o;

    logic [31:0] tcnt = '0;
    logic [31:0] last_start;
    logic [64:0] got [$];
    logic [31:0] exp_q [$];
    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;
    always @(posedge clk) tcnt <= tcnt + 1;
    assign coarse_time_i = tcnt;

    common_start_packer dut_i (
        .clk(clk), .rst_n(rst_n), .coarse_time_i(coarse_time_i), .start_i(start_i),
        .hit_valid_i(hit_valid_i), .hit_trail_i(hit_trail_i), .hit_coarse_i(hit_coarse_i),
        .cfg_edge_mode_i(cfg_edge_mode_i), .cfg_range_i(cfg_range_i),
        .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
        .out_last_o(out_last_o), .missed_o(missed_o)
    );

    // sample one nanosecond before the edge that completes the handshake
    always @(negedge clk) begin
        #9;
        if (rst_n && out_valid_o && out_ready_i) got.push_back({out_last_o, out_data_o});
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] hw(int ch, bit trail, bit coarse, int ofs);
        return {24'(ofs), 1'b0, coarse, 1'b0, trail, 4'(ch)};
    endfunction

    task automatic step(input bit s, input logic [3:0] v, input logic [3:0] tr,
                        input logic [3:0] co);
        @(negedge clk);
        start_i = s; hit_valid_i = v; hit_trail_i = tr; hit_coarse_i = co;
        if (s) last_start = tcnt;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 4'b0, 4'b0, 4'b0);
    endtask

    task automatic check_pkt(input string req, input logic [31:0] t);
        int n = exp_q.size();
        int nw = (n + 1) / 2;
        logic [64:0] e;
        check(got.size() >= nw + 1, req, "word count", 65'(got.size()), 65'(nw + 1));
        if (got.size() < nw + 1) begin
            got.delete();
            return;
        end
        e = {(n == 0), t, 16'(nw), 15'd0, 1'(n % 2)};
        check(got[0] == e, req, "header", got[0], e);
        void'(got.pop_front());
        for (int k = 0; k < nw; k++) begin
            e[31:0]  = exp_q[2*k];
            e[63:32] = (2*k + 1 < n) ? exp_q[2*k+1] : 32'd0;
            e[64]    = (k == nw - 1);
            check(got[0] == e, req, $sformatf("data word %0d", k), got[0], e);
            void'(got.pop_front());
        end
        exp_q.delete();
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(out_valid_o == 1'b0, "R1", "valid in reset", 65'(out_valid_o), 65'd0);
        idle(2);
        rst_n = 1'b1;
        idle(2);
        check(out_valid_o == 1'b0, "R1", "valid after reset", 65'(out_valid_o), 65'd0);
        check(missed_o == '0, "R1", "missed after reset", 65'(missed_o), 65'd0);
    endtask

    // R2 R3 R4 R5 R8: mixed channels, same-cycle ordering, start closes packet
    task automatic t_basic;
        logic [31:0] t1, t2;
        cfg_range_i = 24'd100; cfg_edge_mode_i = 8'hFF; got.delete();
        step(1'b1, 4'b0, 4'b0, 4'b0); t1 = last_start;
        idle(2);
        step(1'b0, 4'b0011, 4'b0001, 4'b0001);
        idle(1);
        step(1'b0, 4'b1000, 4'b0, 4'b0);
        idle(4);
        step(1'b1, 4'b0100, 4'b0, 4'b0); t2 = last_start;
        idle(110);
        exp_q = '{hw(0, 1, 1, 3), hw(1, 0, 0, 3), hw(3, 0, 0, 5)};
        check_pkt("R5", t1);
        exp_q = '{hw(2, 0, 0, 0)};
        check_pkt("R8", t2);
        check(got.size() == 0, "R2", "extra words", 65'(got.size()), 65'd0);
    endtask

    // R6 R7: edge enables and inclusive range boundary, close without new start
    task automatic t_window_edges;
        logic [31:0] t1;
        cfg_range_i = 24'd4; cfg_edge_mode_i = 8'hC9; got.delete();
        step(1'b1, 4'b0, 4'b0, 4'b0); t1 = last_start;
        step(1'b0, 4'b0001, 4'b0000, 4'b0);
        step(1'b0, 4'b0111, 4'b0001, 4'b0);
        step(1'b0, 4'b0010, 4'b0010, 4'b0);
        step(1'b0, 4'b1000, 4'b1000, 4'b0);
        step(1'b0, 4'b1000, 4'b0000, 4'b0);
        idle(15);
        exp_q = '{hw(0, 0, 0, 1), hw(1, 1, 0, 3), hw(3, 1, 0, 4)};
        check_pkt("R6 R7", t1);
        check(got.size() == 0, "R6", "extra words", 65'(got.size()), 65'd0);
    endtask

    // R9 R13 R4(even): early start ignored, idle hits ignored
    task automatic t_gap_even;
        logic [31:0] t1;
        cfg_range_i = 24'd10; cfg_edge_mode_i = 8'hFF; got.delete();
        step(1'b0, 4'b0010, 4'b0, 4'b0);
        idle(1);
        step(1'b1, 4'b0, 4'b0, 4'b0); t1 = last_start;
        step(1'b1, 4'b0, 4'b0, 4'b0);
        step(1'b0, 4'b0001, 4'b0, 4'b0);
        step(1'b0, 4'b1000, 4'b0, 4'b0);
        idle(25);
        exp_q = '{hw(0, 0, 0, 2), hw(3, 0, 0, 3)};
        check_pkt("R9 R13 R4", t1);
        check(got.size() == 0, "R9", "second packet", 65'(got.size()), 65'd0);
    endtask

    // R10 R11: stalled output, second packet dropped and counted
    task automatic t_stall_drop;
        logic [31:0] ta;
        logic [63:0] d1;
        logic [64:0] eh;
        cfg_range_i = 24'd2; cfg_edge_mode_i = 8'hFF; got.delete();
        out_ready_i = 1'b0;
        step(1'b1, 4'b0, 4'b0, 4'b0); ta = last_start;
        step(1'b0, 4'b0001, 4'b0, 4'b0);
        idle(3);
        step(1'b1, 4'b0010, 4'b0, 4'b0);
        idle(6);
        eh = {1'b1, ta, 16'd1, 15'd0, 1'b1};
        check(out_valid_o == 1'b1, "R10", "valid while stalled", 65'(out_valid_o), 65'd1);
        d1 = out_data_o;
        check(d1 == eh[63:0], "R10", "stalled header", 65'(d1), 65'(eh[63:0]));
        idle(3);
        check(out_valid_o && out_data_o == d1, "R10", "held word", 65'(out_data_o), 65'(d1));
        check(missed_o == 16'd1, "R11", "missed count", 65'(missed_o), 65'd1);
        out_ready_i = 1'b1;
        idle(10);
        exp_q = '{hw(0, 0, 0, 1)};
        check_pkt("R11", ta);
        check(got.size() == 0, "R11", "dropped packet emitted", 65'(got.size()), 65'd0);
    endtask

    // R12 R5: capacity limit with four hits per cycle
    task automatic t_overflow;
        logic [31:0] t1;
        cfg_range_i = 24'd20; cfg_edge_mode_i = 8'hFF; got.delete();
        step(1'b1, 4'b0, 4'b0, 4'b0); t1 = last_start;
        for (int i = 0; i < 5; i++) step(1'b0, 4'b1111, 4'b0, 4'b0);
        idle(40);
        for (int o = 1; o <= 4; o++)
            for (int c = 0; c < NCH; c++) exp_q.push_back(hw(c, 0, 0, o));
        check_pkt("R12", t1);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_basic();
        t_window_edges();
        t_gap_even();
        t_stall_drop();
        t_overflow();
        finish_run();
    end
endmodule